// File: doc/BRIEF.md
# Phase Accumulator Waveform Core

This core runs on a single master clock and turns a programmed tuning word into a stream of waveform codes. A 28-bit accumulator adds the chosen frequency word on every enabled cycle. A 12-bit phase offset is added to the top twelve accumulator bits. The sum drives one of two waveform paths: a raw-phase ramp, which stands in for a sine table, or a folded triangle. A separate one-bit square output carries the phase MSB, either directly or divided by two. Each output reaches the pins through a fixed seven-stage pipeline.

Configuration is written through a simple parallel port, one 16-bit word per cycle. The destination is picked by a 3-bit selector: a control word, two frequency words and two phase words. The halt control clears only the accumulator and keeps every configuration register. Software can therefore load the tuning words while halted and then start the output at a known phase. Two low-power controls act separately: one freezes the accumulator, the other parks the waveform code at midscale.

Top module: `wavecore_top`

## Requirements
- R1: While running, the `wave` ramp (bits 27..18 of the accumulator plus offset) advances by the selected frequency word divided by 2^18 every cycle, modulo 1024.
- R2: With control bit 0 (halt) set, the accumulator is held at zero, `wave` reads midscale 512 and `sq_out` is low.
- R3: Halt and its release leave the frequency, phase and control registers unchanged, so the same offset shows again after restart.
- R4: After `rst_n` the outputs read 512 and 0. A control write clearing halt, captured at clock edge k, leaves `wave` at 512 through edge k+6 and shows the restarted phase after edge k+7.
- R5: Control bit 8 selects frequency word 1 over word 0, and bit 9 selects phase word 1 over word 0.
- R6: The phase word (data bits 11..0) is added to the top 12 accumulator bits. With a zero frequency, `wave` equals the offset's top 10 bits.
- R7: Selector values are 0 control, 1 frequency 0, 2 frequency 1, 3 phase 0, 4 phase 1. A frequency write carries 14 data bits (13..0). With control bit 6 set, consecutive writes fill the low half and then the high half; the pairing restarts on any control write. With bit 6 clear, control bit 7 picks the half that is written and the other half is kept.
- R8: With control bit 3 set, `sq_out` is the phase-sum MSB when bit 4 is 1, and that MSB divided by two when bit 4 is 0. With bit 3 clear, `sq_out` is low.
- R9: Control bit 5 selects the triangle path: the upper 11 phase-sum bits, with the low 10 inverted when the top one is 1. When bits 5 and 3 are both set, `sq_out` stays low.
- R10: Control bit 1 freezes the accumulator so `wave` holds steady. Control bit 2 forces `wave` to 512.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| wr_en | input | 1 | Write strobe for one configuration word |
| wr_sel | input | 3 | Destination register selector |
| wr_data | input | 16 | Configuration data |
| wave | output | 10 | Waveform code after the output pipeline |
| sq_out | output | 1 | Square output after the output pipeline |

## Verification
The assertions assume that each write strobe lasts one cycle and carries a selector in the defined range. They also assume that control changes arrive only through the write port, never mid-cycle. The directed stimulus writes one word per call with the strobe high for exactly one clock and uses only the five defined selectors. It puts halt on while tuning words are loaded, then waits out the seven-cycle pipeline before it samples steady-state behaviour.

// File: rtl/wc_pkg.sv
package wc_pkg;
  localparam logic [2:0] SEL_CTRL = 3'd0;
  localparam logic [2:0] SEL_F0   = 3'd1;
  localparam logic [2:0] SEL_F1   = 3'd2;
  localparam logic [2:0] SEL_P0   = 3'd3;
  localparam logic [2:0] SEL_P1   = 3'd4;

  typedef struct packed {
    logic psel;
    logic fsel;
    logic hi_half;
    logic wide;
    logic tri_mode;
    logic sq_full;
    logic sq_en;
    logic dac_off;
    logic clk_off;
    logic halt;
  } ctrl_t;

  function automatic ctrl_t ctrl_decode(input logic [15:0] d);
    ctrl_t c;
    c.halt     = d[0];
    c.clk_off  = d[1];
    c.dac_off  = d[2];
    c.sq_en    = d[3];
    c.sq_full  = d[4];
    c.tri_mode = d[5];
    c.wide     = d[6];
    c.hi_half  = d[7];
    c.fsel     = d[8];
    c.psel     = d[9];
    return c;
  endfunction
endpackage

// File: rtl/wc_regs.sv
module wc_regs
  import wc_pkg::*;
#(
  parameter int ACC_W = 28,
  parameter int PH_W  = 12,
  parameter int DW    = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [2:0]       wr_sel,
  input  logic [DW-1:0]    wr_data,
  output ctrl_t            ctrl,
  output logic [ACC_W-1:0] freq,
  output logic [PH_W-1:0]  phase
);
  localparam int HALF = ACC_W / 2;

  ctrl_t            ctrl_q, ctrl_d;
  logic [ACC_W-1:0] f0_q, f0_d, f1_q, f1_d;
  logic [PH_W-1:0]  p0_q, p0_d, p1_q, p1_d;
  logic             upper_q, upper_d;
  logic             hi_sel;

  function automatic logic [ACC_W-1:0] put_half(input logic [ACC_W-1:0] old,
                                                 input logic hi,
                                                 input logic [HALF-1:0] v);
    logic [ACC_W-1:0] r;
    r = old;
    if (hi) r[ACC_W-1:HALF] = v;
    else    r[HALF-1:0]     = v;
    return r;
  endfunction

  assign hi_sel = ctrl_q.wide ? upper_q : ctrl_q.hi_half;

  always_comb begin
    ctrl_d  = ctrl_q;
    f0_d    = f0_q;
    f1_d    = f1_q;
    p0_d    = p0_q;
    p1_d    = p1_q;
    upper_d = upper_q;
    if (wr_en) begin
      case (wr_sel)
        SEL_CTRL: begin
          ctrl_d  = ctrl_decode(wr_data[15:0]);
          upper_d = 1'b0;
        end
        SEL_F0: begin
          f0_d = put_half(f0_q, hi_sel, wr_data[HALF-1:0]);
          if (ctrl_q.wide) upper_d = ~upper_q;
        end
        SEL_F1: begin
          f1_d = put_half(f1_q, hi_sel, wr_data[HALF-1:0]);
          if (ctrl_q.wide) upper_d = ~upper_q;
        end
        SEL_P0: p0_d = wr_data[PH_W-1:0];
        SEL_P1: p1_d = wr_data[PH_W-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q  <= ctrl_decode(16'h0001);
      f0_q    <= '0;
      f1_q    <= '0;
      p0_q    <= '0;
      p1_q    <= '0;
      upper_q <= 1'b0;
    end else begin
      ctrl_q  <= ctrl_d;
      f0_q    <= f0_d;
      f1_q    <= f1_d;
      p0_q    <= p0_d;
      p1_q    <= p1_d;
      upper_q <= upper_d;
    end
  end

  assign ctrl  = ctrl_q;
  assign freq  = ctrl_q.fsel ? f1_q : f0_q;
  assign phase = ctrl_q.psel ? p1_q : p0_q;

  // R3: only a write aimed at a frequency word may change it
  p_keep_f0_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && wr_sel == SEL_F0) |=> $stable(f0_q));
  p_keep_p0_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && wr_sel == SEL_P0) |=> $stable(p0_q));
  // R7: a narrow low-half write keeps the high half
  p_half_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == SEL_F0 && !ctrl_q.wide && !ctrl_q.hi_half)
      |=> f0_q[ACC_W-1:HALF] == $past(f0_q[ACC_W-1:HALF]));
endmodule

// File: rtl/wc_accum.sv
module wc_accum #(
  parameter int ACC_W = 28,
  parameter int PH_W  = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             halt,
  input  logic             clk_off,
  input  logic [ACC_W-1:0] freq,
  input  logic [PH_W-1:0]  phase,
  output logic [PH_W-1:0]  ph_sum
);
  logic [ACC_W-1:0] acc_q, acc_d;

  always_comb begin
    if (halt)         acc_d = '0;
    else if (clk_off) acc_d = acc_q;
    else              acc_d = acc_q + freq;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) acc_q <= '0;
    else        acc_q <= acc_d;
  end

  assign ph_sum = acc_q[ACC_W-1 -: PH_W] + phase;

  // R2: halt pins the accumulator at zero
  p_halt_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    halt |=> acc_q == '0);
  // R1: one frequency step per running cycle
  p_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!halt && !clk_off) |=> acc_q == $past(acc_q) + $past(freq));
  // R10: frozen accumulator holds still
  p_freeze_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!halt && clk_off) |=> $stable(acc_q));
endmodule

// File: rtl/wc_shaper.sv
module wc_shaper
  import wc_pkg::*;
#(
  parameter int PH_W  = 12,
  parameter int OUT_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  ctrl_t            ctrl,
  input  logic [PH_W-1:0]  ph_sum,
  output logic [OUT_W-1:0] wave_s,
  output logic             sq_s
);
  localparam logic [OUT_W-1:0] MID = OUT_W'(1) << (OUT_W - 1);

  logic             msb_q, msb_d, div_q, div_d;
  logic [OUT_W:0]   tri_src;
  logic [OUT_W-1:0] tri_code, raw_code;

  always_comb begin
    msb_d = ph_sum[PH_W-1];
    if (ctrl.halt)                     div_d = 1'b0;
    else if (ph_sum[PH_W-1] && !msb_q) div_d = ~div_q;
    else                               div_d = div_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      msb_q <= 1'b0;
      div_q <= 1'b0;
    end else begin
      msb_q <= msb_d;
      div_q <= div_d;
    end
  end

  assign tri_src  = ph_sum[PH_W-1 -: OUT_W+1];
  assign tri_code = tri_src[OUT_W] ? ~tri_src[OUT_W-1:0] : tri_src[OUT_W-1:0];
  assign raw_code = ph_sum[PH_W-1 -: OUT_W];

  always_comb begin
    if (ctrl.halt || ctrl.dac_off) wave_s = MID;
    else if (ctrl.tri_mode)        wave_s = tri_code;
    else                           wave_s = raw_code;
    sq_s = ctrl.sq_en && !ctrl.tri_mode && !ctrl.halt &&
           (ctrl.sq_full ? ph_sum[PH_W-1] : div_q);
  end

  // R8: the halved square only changes on an MSB rise or when cleared
  p_div_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(div_q) |-> ($rose(msb_q) || !div_q));
endmodule

// File: rtl/wc_delay.sv
module wc_delay #(
  parameter int             W     = 11,
  parameter int             DEPTH = 7,
  parameter logic [W-1:0]   RST   = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] stg_q [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_stage
    logic [W-1:0] nxt;
    if (i == 0) begin : g_first
      assign nxt = din;
    end else begin : g_rest
      assign nxt = stg_q[i-1];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg_q[i] <= RST;
      else        stg_q[i] <= nxt;
    end
  end

  assign dout = stg_q[DEPTH-1];
endmodule

// File: rtl/wavecore_top.sv
module wavecore_top
  import wc_pkg::*;
#(
  parameter int ACC_W = 28,
  parameter int PH_W  = 12,
  parameter int OUT_W = 10,
  parameter int DW    = 16,
  parameter int LAT   = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [2:0]       wr_sel,
  input  logic [DW-1:0]    wr_data,
  output logic [OUT_W-1:0] wave,
  output logic             sq_out
);
  localparam logic [OUT_W-1:0] MID = OUT_W'(1) << (OUT_W - 1);

  ctrl_t            ctrl;
  logic [ACC_W-1:0] freq;
  logic [PH_W-1:0]  phase, ph_sum;
  logic [OUT_W-1:0] wave_s;
  logic             sq_s;

  wc_regs #(.ACC_W(ACC_W), .PH_W(PH_W), .DW(DW)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .ctrl(ctrl), .freq(freq), .phase(phase));

  wc_accum #(.ACC_W(ACC_W), .PH_W(PH_W)) u_acc (
    .clk(clk), .rst_n(rst_n), .halt(ctrl.halt), .clk_off(ctrl.clk_off),
    .freq(freq), .phase(phase), .ph_sum(ph_sum));

  wc_shaper #(.PH_W(PH_W), .OUT_W(OUT_W)) u_shape (
    .clk(clk), .rst_n(rst_n), .ctrl(ctrl), .ph_sum(ph_sum),
    .wave_s(wave_s), .sq_s(sq_s));

  wc_delay #(.W(OUT_W+1), .DEPTH(LAT), .RST({1'b0, MID})) u_pipe (
    .clk(clk), .rst_n(rst_n), .din({sq_s, wave_s}), .dout({sq_out, wave}));

  // R2: while halted the pre-pipeline outputs sit at midscale and low
  p_halt_mid_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl.halt |-> (wave_s == MID && !sq_s));
  // R9: triangle plus square never drives the square high
  p_tri_sq_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl.tri_mode && ctrl.sq_en) |-> !sq_s);
endmodule

// File: tb/sim_wavecore_top.sv
module sim_wavecore_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_sel = 3'd0;
  logic [15:0] wr_data = 16'd0;
  logic [9:0]  wave;
  logic        sq_out;
  int          checks = 0;
  int          errors = 0;
  bit          done = 1'b0;

  localparam logic [15:0] C_HALT = 16'h0001, C_FRZ = 16'h0002, C_DOFF = 16'h0004,
                          C_SQEN = 16'h0008, C_SQF = 16'h0010, C_TRI = 16'h0020,
                          C_WIDE = 16'h0040, C_HI = 16'h0080, C_FS = 16'h0100,
                          C_PS = 16'h0200;

  always #2.5 clk = ~clk;

  wavecore_top u0 (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
                   .wr_data(wr_data), .wave(wave), .sq_out(sq_out));

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] s, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = s; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic settle();
    repeat (10) @(negedge clk);
  endtask

  // loads a 28-bit word in two halves using the paired mode (R7)
  task automatic set_freq(input logic [2:0] s, input logic [27:0] v);
    wr(3'd0, C_HALT | C_WIDE);
    wr(s, {2'b00, v[13:0]});
    wr(s, {2'b00, v[27:14]});
  endtask

  task automatic slope(input string req, input int step);
    int prev;
    settle();
    prev = wave;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check(req, (int'(wave) - prev + 1024) % 1024, step);
      prev = wave;
    end
  endtask

  task automatic t_reset();
    check("R4 reset wave", wave, 512);
    check("R4 reset sq", sq_out, 0);
  endtask

  task automatic t_latency();
    set_freq(3'd1, 28'd0);
    wr(3'd3, 16'h400);
    settle();
    check("R2 halted midscale", wave, 512);
    wr(3'd0, 16'h0000);
    repeat (6) @(negedge clk);
    check("R4 still midscale at k+6", wave, 512);
    @(negedge clk);
    check("R4 R6 offset at k+7", wave, 256);
    wr(3'd0, C_HALT);
    settle();
    check("R2 halt again", wave, 512);
    wr(3'd0, 16'h0000);
    settle();
    check("R3 offset kept", wave, 256);
  endtask

  task automatic t_slope();
    set_freq(3'd1, 28'h004_0000);
    wr(3'd3, 16'h000);
    wr(3'd0, 16'h0000);
    slope("R1 step one", 1);
    wr(3'd0, C_HALT | C_HI);
    wr(3'd2, 16'd32);
    wr(3'd0, C_HALT);
    wr(3'd2, 16'd5);
    wr(3'd0, C_FS);
    slope("R5 R7 narrow halves", 2);
    wr(3'd0, 16'h0000);
    slope("R5 back to word0", 1);
  endtask

  task automatic t_phase_sel();
    set_freq(3'd1, 28'd0);
    wr(3'd3, 16'h400);
    wr(3'd4, 16'hC00);
    wr(3'd0, 16'h0000);
    settle();
    check("R5 phase0", wave, 256);
    wr(3'd0, C_PS);
    settle();
    check("R5 R6 phase1", wave, 768);
  endtask

  task automatic t_tri();
    wr(3'd3, 16'h300);
    wr(3'd0, C_TRI);
    settle();
    check("R9 tri rising", wave, 384);
    wr(3'd3, 16'hD00);
    settle();
    check("R9 tri folded", wave, 383);
  endtask

  task automatic t_sleep();
    set_freq(3'd1, 28'h004_0000);
    wr(3'd3, 16'h000);
    wr(3'd0, 16'h0000);
    settle();
    wr(3'd0, C_FRZ);
    settle();
    begin
      int a;
      a = wave;
      repeat (3) @(negedge clk);
      check("R10 frozen", wave, a);
    end
    wr(3'd0, C_DOFF);
    settle();
    check("R10 dac off midscale", wave, 512);
  endtask

  task automatic count_edges(input string req, input int exp);
    int n, prev;
    settle();
    n = 0;
    prev = sq_out;
    for (int i = 0; i < 256; i++) begin
      @(negedge clk);
      if (int'(sq_out) != prev) n++;
      prev = sq_out;
    end
    check(req, n, exp);
  endtask

  task automatic t_square();
    set_freq(3'd1, 28'h040_0000);
    wr(3'd0, 16'h0000);
    count_edges("R8 sq disabled", 0);
    wr(3'd0, C_SQEN | C_SQF);
    count_edges("R8 sq full", 8);
    wr(3'd0, C_SQEN);
    count_edges("R8 sq halved", 4);
    wr(3'd0, C_SQEN | C_SQF | C_TRI);
    settle();
    begin
      int hi;
      hi = 0;
      for (int i = 0; i < 100; i++) begin
        @(negedge clk);
        if (sq_out) hi++;
      end
      check("R9 tri with sq low", hi, 0);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_latency();
    t_slope();
    t_phase_sel();
    t_tri();
    t_sleep();
    t_square();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule